// File: doc/BRIEF.md
# Power-Budgeted Phase Arbiter for a Shared Bus

This block grants a shared bus to four masters and, alongside that, governs which coarse activity phase each master may run in. Each phase has a power cost and a rank, both held in small programmable tables. Ordinary bus requests are served by fixed priority: the lowest master index wins. A master that wants to change phase strobes a phase request with the phase number it wants. The arbiter holds that request as pending. It approves the request only if the summed power of all masters' current phases, recomputed with the new phase in place of the old one, stays at or below a programmable limit.

While a phase change is pending, that master gets no bus grants. A denied change stays pending and is tried again on every cycle, so a master can be held back purely to keep the total power within the limit. When several masters are pending, the arbiter approves the highest-ranked one that fits. Because a pending change that does not fit never blocks one that does, pending masters cannot wait on one another in a cycle.

Top module: `power_phase_arbiter`

## Requirements
- R1: After reset, bus_gnt, ph_gnt and ph_pending are all zero, every master is in phase 0, all table entries and the limit are zero, and total_power reads 0.
- R2: A configuration write takes effect from the next cycle. cfg_sel 0 writes power entry cfg_addr with cfg_data[7:0]. cfg_sel 1 writes rank entry cfg_addr with cfg_data[1:0]. cfg_sel 2 or 3 writes the power limit with cfg_data[9:0].
- R3: bus_gnt is registered and has at most one bit set. One cycle after a set of eligible bus requests, it grants the lowest-indexed one. With no eligible request it is zero.
- R4: A ph_req strobe from a master that is not pending captures ph_target[3i+2:3i] and makes the master pending from the next cycle. A strobe from a master that is already pending is ignored, and its captured target is kept.
- R5: A master is not eligible for the bus in a cycle in which it is pending or in which it strobes ph_req.
- R6: A pending master whose change is approved moves to its target phase, leaves pending, and pulses ph_gnt for one cycle, all at the same clock edge. The earliest approval comes at the second edge after the strobe.
- R7: A change is approved only if total_power - power[current] + power[target] <= limit. A denied change stays pending and is evaluated again on every later cycle.
- R8: At most one change is approved per cycle. Among the pending changes that fit, the one whose target phase has the highest rank wins, and equal ranks go to the lower master index.
- R9: A higher-ranked pending change that does not fit does not stop a lower-ranked one that fits from being approved.
- R10: total_power always equals the sum of the power entries of the four masters' current phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 4 | Ordinary bus request per master |
| bus_gnt | output | 4 | Registered bus grant, at most one bit set |
| ph_req | input | 4 | One-cycle strobe asking for a phase change |
| ph_target | input | 12 | Requested phase, 3 bits per master, master i at [3i+2:3i] |
| ph_gnt | output | 4 | One-cycle pulse when a master's phase change is approved |
| ph_pending | output | 4 | Master has a phase change waiting |
| ph_current | output | 12 | Current phase, 3 bits per master, master i at [3i+2:3i] |
| total_power | output | 10 | Sum of the power entries of the current phases |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | 0 power table, 1 rank table, 2 or 3 power limit |
| cfg_addr | input | 3 | Table entry (phase number) |
| cfg_data | input | 10 | Write data |

## Verification
A bus grant is due one edge after its request. A phase strobe shows up as pending one edge later, and its approval comes at the earliest one edge after that. At that edge the approval pulse, the new current phase and the new total_power all appear together. A table or limit write changes total_power and later decisions from the next edge. The driver pushes onto the scoreboard queue, at each falling edge, the outputs that its model predicts for the coming rising edge. The monitor pops and compares one nanosecond after that rising edge, so every comparison sees exactly the edge its stimulus belongs to.

// File: rtl/pma_pkg.sv
package pma_pkg;
  localparam int unsigned MST_N   = 4;
  localparam int unsigned PHASE_W = 3;
  localparam int unsigned POWER_W = 8;
  localparam int unsigned RANK_W  = 2;

  typedef enum logic [1:0] {
    CFG_POWER  = 2'd0,
    CFG_RANK   = 2'd1,
    CFG_LIMIT  = 2'd2,
    CFG_LIMIT2 = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/pma_tables.sv
module pma_tables
  import pma_pkg::*;
#(
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned EW = POWER_W,
  parameter int unsigned RW = RANK_W,
  parameter int unsigned SW = POWER_W + 2,
  localparam int unsigned NS = 1 << PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [PW-1:0] cfg_addr,
  input  logic [SW-1:0] cfg_data,
  output logic [EW-1:0] pwr_tab  [NS],
  output logic [RW-1:0] rank_tab [NS],
  output logic [SW-1:0] limit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NS; e++) begin
        pwr_tab[e]  <= '0;
        rank_tab[e] <= '0;
      end
      limit <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_POWER: pwr_tab[cfg_addr]  <= cfg_data[EW-1:0];
        CFG_RANK:  rank_tab[cfg_addr] <= cfg_data[RW-1:0];
        default:   limit              <= cfg_data;
      endcase
    end
  end
endmodule

// File: rtl/pma_phase_sel.sv
module pma_phase_sel #(
  parameter int unsigned N  = 4,
  parameter int unsigned PW = 3,
  parameter int unsigned EW = 8,
  parameter int unsigned RW = 2,
  parameter int unsigned SW = 10,
  localparam int unsigned NS = 1 << PW
) (
  input  logic [N-1:0]  pend,
  input  logic [PW-1:0] cur      [N],
  input  logic [PW-1:0] tgt      [N],
  input  logic [EW-1:0] pwr_tab  [NS],
  input  logic [RW-1:0] rank_tab [NS],
  input  logic [SW-1:0] limit,
  output logic [SW-1:0] total,
  output logic [N-1:0]  win
);
  function automatic logic [SW:0] widen(input logic [EW-1:0] v);
    logic [SW:0] w;
    w = '0;
    w[EW-1:0] = v;
    return w;
  endfunction

  // projected sum after swapping one master's phase cost
  function automatic logic within_limit(input logic [SW-1:0] sum,
                                        input logic [EW-1:0] leave,
                                        input logic [EW-1:0] enter,
                                        input logic [SW-1:0] lim);
    logic [SW:0] proj;
    proj = {1'b0, sum} - widen(leave) + widen(enter);
    return proj <= {1'b0, lim};
  endfunction

  logic [N-1:0] fit;

  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) total = total + SW'(pwr_tab[cur[i]]);
  end

  for (genvar i = 0; i < N; i++) begin : g_fit
    assign fit[i] = pend[i] &&
                    within_limit(total, pwr_tab[cur[i]], pwr_tab[tgt[i]], limit);
  end

  // highest target rank among fitting candidates, ties to the lower index
  always_comb begin
    logic          found;
    logic [RW-1:0] best_rank;
    found     = 1'b0;
    best_rank = '0;
    win       = '0;
    for (int i = 0; i < N; i++) begin
      if (fit[i] && (!found || rank_tab[tgt[i]] > best_rank)) begin
        found     = 1'b1;
        best_rank = rank_tab[tgt[i]];
        win       = '0;
        win[i]    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pma_bus_pick.sv
module pma_bus_pick #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] hold,
  output logic [N-1:0] gnt
);
  function automatic logic [N-1:0] lowest_one(input logic [N-1:0] v);
    return v & (~v + N'(1));
  endfunction

  logic [N-1:0] elig;
  assign elig = req & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt <= '0;
    else        gnt <= lowest_one(elig);
  end

  // R3
  bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R3
  bus_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |=> (|gnt));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5
    bus_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold[i] |=> !gnt[i]);
  end
endmodule

// File: rtl/power_phase_arbiter.sv
module power_phase_arbiter
  import pma_pkg::*;
#(
  parameter int unsigned N  = MST_N,
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned EW = POWER_W,
  parameter int unsigned RW = RANK_W,
  localparam int unsigned SW = EW + $clog2(N),
  localparam int unsigned NS = 1 << PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    bus_req,
  output logic [N-1:0]    bus_gnt,
  input  logic [N-1:0]    ph_req,
  input  logic [N*PW-1:0] ph_target,
  output logic [N-1:0]    ph_gnt,
  output logic [N-1:0]    ph_pending,
  output logic [N*PW-1:0] ph_current,
  output logic [SW-1:0]   total_power,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [PW-1:0]   cfg_addr,
  input  logic [SW-1:0]   cfg_data
);
  logic [PW-1:0] cur_q [N];
  logic [PW-1:0] tgt_q [N];
  logic [N-1:0]  pend_q;
  logic [N-1:0]  gnt_q;
  logic [N-1:0]  win;
  logic [EW-1:0] pwr_tab  [NS];
  logic [RW-1:0] rank_tab [NS];
  logic [SW-1:0] limit_q;

  pma_tables #(.PW(PW), .EW(EW), .RW(RW), .SW(SW)) u_tables (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .pwr_tab  (pwr_tab),
    .rank_tab (rank_tab),
    .limit    (limit_q)
  );

  pma_phase_sel #(.N(N), .PW(PW), .EW(EW), .RW(RW), .SW(SW)) u_sel (
    .pend     (pend_q),
    .cur      (cur_q),
    .tgt      (tgt_q),
    .pwr_tab  (pwr_tab),
    .rank_tab (rank_tab),
    .limit    (limit_q),
    .total    (total_power),
    .win      (win)
  );

  pma_bus_pick #(.N(N)) u_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (bus_req),
    .hold  (pend_q | ph_req),
    .gnt   (bus_gnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        cur_q[i] <= '0;
        tgt_q[i] <= '0;
      end
      pend_q <= '0;
      gnt_q  <= '0;
    end else begin
      gnt_q <= win;
      for (int i = 0; i < N; i++) begin
        if (win[i]) begin
          cur_q[i]  <= tgt_q[i];
          pend_q[i] <= 1'b0;
        end else if (!pend_q[i] && ph_req[i]) begin
          pend_q[i] <= 1'b1;
          tgt_q[i]  <= ph_target[i*PW +: PW];
        end
      end
    end
  end

  assign ph_gnt     = gnt_q;
  assign ph_pending = pend_q;

  for (genvar i = 0; i < N; i++) begin : g_out
    assign ph_current[i*PW +: PW] = cur_q[i];

    // R5
    pend_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_pending[i] |-> !bus_gnt[i]);

    // R7
    denied_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !win[i]) |=> (pend_q[i] && $stable(tgt_q[i])));

    // R6
    gnt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_gnt[i] |-> !ph_pending[i]);
  end

  // R8
  one_phase_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ph_gnt));

  // R7
  limit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ph_gnt) && !$past(cfg_we)) |-> (total_power <= limit_q));
endmodule

// File: tb/test_power_phase_arbiter.sv
module test_power_phase_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_req = '0;
  logic [3:0]  ph_req = '0;
  logic [11:0] ph_target = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [2:0]  cfg_addr = '0;
  logic [9:0]  cfg_data = '0;
  logic [3:0]  bus_gnt, ph_gnt, ph_pending;
  logic [11:0] ph_current;
  logic [9:0]  total_power;

  always #5 clk = ~clk;

  power_phase_arbiter i_power_phase_arbiter (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .ph_req(ph_req), .ph_target(ph_target), .ph_gnt(ph_gnt),
    .ph_pending(ph_pending), .ph_current(ph_current),
    .total_power(total_power), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data));

  typedef struct {
    logic [3:0]  bg;
    logic [3:0]  mg;
    logic [3:0]  pd;
    logic [11:0] cur;
    logic [9:0]  tot;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int fails = 0;

  int m_pwr[8];
  int m_rank[8];
  int m_lim;
  int m_cur[4];
  int m_tgt[4];
  bit m_pend[4];

  task automatic expect_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] tg(input int a, input int b, input int c, input int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  task automatic step(input logic [3:0] br, input logic [3:0] pr, input logic [11:0] pt,
                      input logic we, input logic [1:0] sel, input logic [2:0] a,
                      input logic [9:0] d, input string tag);
    item_t it;
    int tot;
    int best;
    bit was_pend[4];
    @(negedge clk);
    bus_req = br; ph_req = pr; ph_target = pt;
    cfg_we = we; cfg_sel = sel; cfg_addr = a; cfg_data = d;
    it.bg = '0;
    for (int i = 0; i < 4; i++)
      if (br[i] && !m_pend[i] && !pr[i]) begin it.bg[i] = 1'b1; break; end
    tot = 0;
    for (int i = 0; i < 4; i++) tot += m_pwr[m_cur[i]];
    best = -1;
    for (int p = 3; p >= 0; p--)
      for (int i = 0; i < 4; i++)
        if (best < 0 && m_pend[i] && m_rank[m_tgt[i]] == p &&
            tot - m_pwr[m_cur[i]] + m_pwr[m_tgt[i]] <= m_lim) best = i;
    for (int i = 0; i < 4; i++) was_pend[i] = m_pend[i];
    it.mg = '0;
    if (best >= 0) begin
      m_cur[best] = m_tgt[best]; m_pend[best] = 1'b0; it.mg[best] = 1'b1;
    end
    for (int i = 0; i < 4; i++)
      if (pr[i] && !was_pend[i]) begin m_pend[i] = 1'b1; m_tgt[i] = int'(pt[i*3 +: 3]); end
    if (we) begin
      case (sel)
        2'd0: m_pwr[a] = int'(d[7:0]);
        2'd1: m_rank[a] = int'(d[1:0]);
        default: m_lim = int'(d);
      endcase
    end
    tot = 0;
    for (int i = 0; i < 4; i++) begin
      it.pd[i] = m_pend[i];
      it.cur[i*3 +: 3] = 3'(m_cur[i]);
      tot += m_pwr[m_cur[i]];
    end
    it.tot = 10'(tot);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic cyc(input logic [3:0] br, input logic [3:0] pr, input logic [11:0] pt,
                     input string tag);
    step(br, pr, pt, 1'b0, 2'd0, 3'd0, 10'd0, tag);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [2:0] a, input logic [9:0] d);
    step(4'd0, 4'd0, 12'd0, 1'b1, sel, a, d, "cfg");
  endtask

  task automatic look();
    @(posedge clk);
    #2;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    if (sb.size() != 0) begin
      item_t e;
      #1;
      e = sb.pop_front();
      expect_eq({"R3 bus_gnt ", e.tag}, int'(bus_gnt), int'(e.bg));
      expect_eq({"R6 ph_gnt ", e.tag}, int'(ph_gnt), int'(e.mg));
      expect_eq({"R4 ph_pending ", e.tag}, int'(ph_pending), int'(e.pd));
      expect_eq({"R6 ph_current ", e.tag}, int'(ph_current), int'(e.cur));
      expect_eq({"R10 total_power ", e.tag}, int'(total_power), int'(e.tot));
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int pv[8];
    int rv[8];
    logic [31:0] r;
    logic [31:0] s;
    pv = '{0, 10, 40, 100, 200, 5, 60, 250};
    rv = '{0, 1, 3, 2, 0, 3, 1, 2};
    for (int i = 0; i < 8; i++) begin m_pwr[i] = 0; m_rank[i] = 0; end
    for (int i = 0; i < 4; i++) begin m_cur[i] = 0; m_tgt[i] = 0; m_pend[i] = 0; end
    m_lim = 0;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    look();
    // R1 reset state
    expect_eq("R1 bus_gnt", int'(bus_gnt), 0);
    expect_eq("R1 ph_gnt", int'(ph_gnt), 0);
    expect_eq("R1 ph_pending", int'(ph_pending), 0);
    expect_eq("R1 ph_current", int'(ph_current), 0);
    expect_eq("R1 total_power", int'(total_power), 0);

    for (int i = 0; i < 8; i++) cfg(2'd0, 3'(i), 10'(pv[i]));
    for (int i = 0; i < 8; i++) cfg(2'd1, 3'(i), 10'(rv[i]));
    cfg(2'd2, 3'd0, 10'd300);
    // R2 power entry write visible next cycle
    cfg(2'd0, 3'd0, 10'd7); look();
    expect_eq("R2 total after write", int'(total_power), 28);
    cfg(2'd0, 3'd0, 10'd0);

    // R3 fixed priority
    cyc(4'b1110, 4'd0, 12'd0, "R3"); look();
    expect_eq("R3 lowest wins", int'(bus_gnt), 4'b0010);
    cyc(4'b1000, 4'd0, 12'd0, "R3"); look();
    expect_eq("R3 single", int'(bus_gnt), 4'b1000);
    cyc(4'b0000, 4'd0, 12'd0, "R3"); look();
    expect_eq("R3 none", int'(bus_gnt), 0);

    // R6 approval timing
    cyc(4'd0, 4'b0010, tg(0, 3, 0, 0), "R6"); look();
    expect_eq("R6 pending after strobe", int'(ph_pending), 4'b0010);
    expect_eq("R6 no early grant", int'(ph_gnt), 0);
    cyc(4'd0, 4'd0, 12'd0, "R6"); look();
    expect_eq("R6 grant pulse", int'(ph_gnt), 4'b0010);
    expect_eq("R6 new phase", int'(ph_current[5:3]), 3);
    expect_eq("R10 total", int'(total_power), 100);

    // R7 / R9 / R5 denial and bypass
    cyc(4'b0001, 4'b0101, tg(7, 0, 1, 0), "R5"); look();
    expect_eq("R5 strobe blocks bus", int'(bus_gnt), 0);
    expect_eq("R4 captured", int'(ph_pending), 4'b0101);
    cyc(4'b0001, 4'd0, 12'd0, "R9"); look();
    expect_eq("R9 fitting lower rank wins", int'(ph_gnt), 4'b0100);
    expect_eq("R5 pending blocks bus", int'(bus_gnt), 0);
    cyc(4'b0001, 4'b0010, tg(0, 0, 0, 0), "R7"); look();
    expect_eq("R7 over limit denied", int'(ph_gnt), 0);
    expect_eq("R7 still pending", int'(ph_pending), 4'b0011);
    cyc(4'b0001, 4'd0, 12'd0, "R7"); look();
    expect_eq("R9 power drop approved", int'(ph_gnt), 4'b0010);
    cyc(4'b0001, 4'd0, 12'd0, "R7"); look();
    expect_eq("R7 retried and approved", int'(ph_gnt), 4'b0001);
    expect_eq("R7 phase 7", int'(ph_current[2:0]), 7);
    cyc(4'b0001, 4'd0, 12'd0, "R5"); look();
    expect_eq("R5 bus after approval", int'(bus_gnt), 4'b0001);
    cyc(4'd0, 4'b0001, tg(0, 0, 0, 0), "R7");
    cyc(4'd0, 4'd0, 12'd0, "R7");

    // R8 rank order and tie
    cyc(4'd0, 4'b1010, tg(0, 6, 0, 2), "R8");
    cyc(4'd0, 4'd0, 12'd0, "R8"); look();
    expect_eq("R8 higher rank first", int'(ph_gnt), 4'b1000);
    cyc(4'd0, 4'd0, 12'd0, "R8"); look();
    expect_eq("R8 then lower rank", int'(ph_gnt), 4'b0010);
    cyc(4'd0, 4'b0101, tg(5, 0, 2, 0), "R8");
    cyc(4'd0, 4'd0, 12'd0, "R8"); look();
    expect_eq("R8 tie lower index", int'(ph_gnt), 4'b0001);
    cyc(4'd0, 4'd0, 12'd0, "R8"); look();
    expect_eq("R8 tie second", int'(ph_gnt), 4'b0100);

    // R4 re-strobe while pending ignored
    cfg(2'd2, 3'd0, 10'd145);
    cyc(4'd0, 4'b0010, tg(0, 7, 0, 0), "R4");
    cyc(4'd0, 4'd0, 12'd0, "R4"); look();
    expect_eq("R4 denied", int'(ph_gnt), 0);
    cyc(4'd0, 4'b0010, tg(0, 0, 0, 0), "R4"); look();
    expect_eq("R4 second strobe ignored", int'(ph_gnt), 0);
    expect_eq("R4 still pending", int'(ph_pending), 4'b0010);
    cfg(2'd3, 3'd0, 10'd400); look();
    expect_eq("R2 limit not yet used", int'(ph_gnt), 0);
    cyc(4'd0, 4'd0, 12'd0, "R4"); look();
    expect_eq("R2 raised limit approves", int'(ph_gnt), 4'b0010);
    expect_eq("R4 first target kept", int'(ph_current[5:3]), 7);

    // mixed traffic against the model
    r = 32'h1234_5678;
    s = 32'h9abc_def1;
    for (int n = 0; n < 600; n++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      step(r[3:0], r[7:4] & r[11:8], r[27:16], (s[2:0] == 3'd0), s[4:3], s[7:5],
           s[17:8], "R8 mixed");
    end
    for (int n = 0; n < 4; n++) cyc(4'd0, 4'd0, 12'd0, "drain");
    repeat (3) @(posedge clk);
    #3;
    summary();
  end
endmodule